// File: doc/BRIEF.md
# Four-Beat Wide Search Command Capture

This block sits at the command input of a ternary search engine. A host issues one 272-bit search as four back-to-back beats on a 68-bit data bus, with a 9-bit command field beside it. The block checks every beat, assembles the 272-bit key in order, and collects the control fields carried in the command bits. Which bits hold which field depends on the beat being sampled.

When the fourth beat is accepted, the block emits a one-cycle launch pulse in the next cycle. The full key, two global-mask pair indexes, the two upper result-address bits and the result-register index are presented together with the pulse and held until the next launch. A broken sequence is dropped and flagged for one cycle, and the block then waits for a new first beat.

Top module: `wide_search_capture`

## Requirements
- R1: A beat is qualified only when `cmd_valid_i` is 1 and `cmd_i[1:0]` equals 2'b10. Any other beat never advances the sequence.
- R2: While idle, a qualified beat with `cmd_i[2]` = 1 is taken as the first beat (A). A qualified beat with `cmd_i[2]` = 0, or an unqualified beat, is ignored while idle: no launch and no error.
- R3: On launch, `key_o[271:204]` holds the data of beat A, `[203:136]` beat B, `[135:68]` beat C and `[67:0]` beat D.
- R4: `midx_hi_o` equals `cmd_i[5:3]` of beat A, and `midx_lo_o` equals `cmd_i[5:3]` of beat C.
- R5: `addr_hi_o` equals `cmd_i[8:7]` of beat C. The value of `cmd_i[8:7]` in beat A has no effect on it.
- R6: `rsel_o` equals `cmd_i[8:6]` of beat D. The value of `cmd_i[5:2]` in beat D has no effect on any output.
- R7: `launch_o` is 1 for exactly the one cycle after beat D is sampled.
- R8: An unqualified beat in place of beat B, C or D aborts the sequence. `proto_err_o` is 1 for exactly the next cycle, no launch follows, and the aborting beat does not start a new sequence.
- R9: A beat C with `cmd_i[2]` = 1 aborts the sequence in the same way as R8.
- R10: Reset clears all outputs to zero. Between launches, the key and field outputs keep their last launched values.
- R11: A beat A sampled in the cycle right after beat D starts a new sequence with no idle cycle lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command-valid strobe |
| cmd_i | input | 9 | Command field; meaning depends on the beat |
| data_i | input | 68 | Key slice for the current beat |
| launch_o | output | 1 | One-cycle launch pulse |
| proto_err_o | output | 1 | One-cycle protocol-error pulse |
| key_o | output | 272 | Assembled search key |
| midx_hi_o | output | 3 | Mask pair index for key bits [271:136] |
| midx_lo_o | output | 3 | Mask pair index for key bits [135:0] |
| addr_hi_o | output | 2 | Result address bits [21:20] |
| rsel_o | output | 3 | Result register index |

## Verification
Full sequences are swept over every combination of both mask indexes, the address bits and the register index. Each beat carries a distinct data word, so a swapped key slot or a field taken from the wrong beat shows up as a mismatch. The ignored bit positions carry values that differ from the real fields. Each abort cause is injected at each position where it is checked, followed by quiet cycles that show the outputs still hold the last launch. Other patterns cover idle beats that must not start a sequence, stray B/C/D beats after an abort, and a second sequence that follows a launch with no gap.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [1:0] {
    PH_A = 2'd0,
    PH_B = 2'd1,
    PH_C = 2'd2,
    PH_D = 2'd3
  } phase_t;

  localparam logic [1:0] OPC_SEARCH = 2'b10;
endpackage

// File: rtl/wsc_beat_decode.sv
module wsc_beat_decode
  import wsc_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] opc_i,
  input  logic       wide_i,
  output logic       qual_o,
  output logic       wide_o
);
  // A beat belongs to a search only with the strobe high and the search opcode
  assign qual_o = valid_i && (opc_i == OPC_SEARCH);
  assign wide_o = wide_i;
endmodule

// File: rtl/wsc_sequencer.sv
module wsc_sequencer
  import wsc_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qual_i,
  input  logic             wide_i,
  output logic [BEATS-1:0] cap_o,
  output logic             launch_o,
  output logic             err_o
);
  phase_t phase_q, phase_n;
  logic   accept, abort;

  always_comb begin
    phase_n = phase_q;
    accept  = 1'b0;
    abort   = 1'b0;
    unique case (phase_q)
      PH_A: begin
        if (qual_i && wide_i) begin
          accept  = 1'b1;
          phase_n = PH_B;
        end
      end
      PH_B: begin
        if (qual_i) begin
          accept  = 1'b1;
          phase_n = PH_C;
        end else begin
          abort   = 1'b1;
          phase_n = PH_A;
        end
      end
      PH_C: begin
        if (qual_i && !wide_i) begin
          accept  = 1'b1;
          phase_n = PH_D;
        end else begin
          abort   = 1'b1;
          phase_n = PH_A;
        end
      end
      PH_D: begin
        phase_n = PH_A;
        if (qual_i) accept = 1'b1;
        else        abort  = 1'b1;
      end
      default: phase_n = PH_A;
    endcase
  end

  // one strobe per beat position, driven only when that beat is accepted
  for (genvar g = 0; g < BEATS; g++) begin : g_cap
    assign cap_o[g] = accept && (phase_q == phase_t'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_A;
      launch_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      launch_o <= accept && (phase_q == PH_D);
      err_o    <= abort;
    end
  end
endmodule

// File: rtl/wsc_key_collect.sv
module wsc_key_collect #(
  parameter int DATA_W = 68,
  parameter int BEATS  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [BEATS-1:0]        cap_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic [DATA_W*BEATS-1:0] key_o
);
  localparam int KEY_W = DATA_W * BEATS;
  localparam int SLOTS = BEATS - 1;

  logic [DATA_W-1:0] slot_q [SLOTS];
  logic [KEY_W-1:0]  key_n;

  // staging slots for every beat but the last; no reset needed on data
  always_ff @(posedge clk) begin
    for (int g = 0; g < SLOTS; g++) begin
      if (cap_i[g]) slot_q[g] <= data_i;
    end
  end

  // earliest beat lands in the most significant slice
  always_comb begin
    key_n = '0;
    for (int g = 0; g < SLOTS; g++) begin
      key_n[KEY_W-1-g*DATA_W -: DATA_W] = slot_q[g];
    end
    key_n[DATA_W-1:0] = data_i;
  end

  always_ff @(posedge clk) begin
    if (rst)                key_o <= '0;
    else if (cap_i[BEATS-1]) key_o <= key_n;
  end
endmodule

// File: rtl/wsc_field_latch.sv
module wsc_field_latch #(
  parameter int MIDX_W = 3,
  parameter int AHI_W  = 2,
  parameter int RSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_a_i,
  input  logic              cap_c_i,
  input  logic              cap_d_i,
  input  logic [MIDX_W-1:0] midx_i,
  input  logic [AHI_W-1:0]  ahi_i,
  input  logic [RSEL_W-1:0] rsel_i,
  output logic [MIDX_W-1:0] midx_hi_o,
  output logic [MIDX_W-1:0] midx_lo_o,
  output logic [AHI_W-1:0]  addr_hi_o,
  output logic [RSEL_W-1:0] rsel_o
);
  logic [MIDX_W-1:0] hi_q, lo_q;
  logic [AHI_W-1:0]  ahi_q;

  // staged while the sequence runs, so an aborted sequence leaves outputs alone
  always_ff @(posedge clk) begin
    if (cap_a_i) hi_q <= midx_i;
    if (cap_c_i) begin
      lo_q  <= midx_i;
      ahi_q <= ahi_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      midx_hi_o <= '0;
      midx_lo_o <= '0;
      addr_hi_o <= '0;
      rsel_o    <= '0;
    end else if (cap_d_i) begin
      midx_hi_o <= hi_q;
      midx_lo_o <= lo_q;
      addr_hi_o <= ahi_q;
      rsel_o    <= rsel_i;
    end
  end
endmodule

// File: rtl/wide_search_capture.sv
module wide_search_capture
  import wsc_pkg::*;
#(
  parameter int DATA_W = 68,
  parameter int CMD_W  = 9,
  parameter int MIDX_W = 3,
  parameter int AHI_W  = 2,
  parameter int RSEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid_i,
  input  logic [CMD_W-1:0]      cmd_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic                  launch_o,
  output logic                  proto_err_o,
  output logic [DATA_W*4-1:0]   key_o,
  output logic [MIDX_W-1:0]     midx_hi_o,
  output logic [MIDX_W-1:0]     midx_lo_o,
  output logic [AHI_W-1:0]      addr_hi_o,
  output logic [RSEL_W-1:0]     rsel_o
);
  localparam int BEATS    = 4;
  localparam int WIDE_BIT = 2;
  localparam int MIDX_LSB = WIDE_BIT + 1;

  logic             qual, wide;
  logic [BEATS-1:0] cap;

  wsc_beat_decode u_decode (
    .valid_i (cmd_valid_i),
    .opc_i   (cmd_i[1:0]),
    .wide_i  (cmd_i[WIDE_BIT]),
    .qual_o  (qual),
    .wide_o  (wide)
  );

  wsc_sequencer #(.BEATS(BEATS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .qual_i   (qual),
    .wide_i   (wide),
    .cap_o    (cap),
    .launch_o (launch_o),
    .err_o    (proto_err_o)
  );

  wsc_key_collect #(.DATA_W(DATA_W), .BEATS(BEATS)) u_key (
    .clk    (clk),
    .rst    (rst),
    .cap_i  (cap),
    .data_i (data_i),
    .key_o  (key_o)
  );

  wsc_field_latch #(.MIDX_W(MIDX_W), .AHI_W(AHI_W), .RSEL_W(RSEL_W)) u_fields (
    .clk       (clk),
    .rst       (rst),
    .cap_a_i   (cap[0]),
    .cap_c_i   (cap[2]),
    .cap_d_i   (cap[3]),
    .midx_i    (cmd_i[MIDX_LSB +: MIDX_W]),
    .ahi_i     (cmd_i[CMD_W-1 -: AHI_W]),
    .rsel_i    (cmd_i[CMD_W-1 -: RSEL_W]),
    .midx_hi_o (midx_hi_o),
    .midx_lo_o (midx_lo_o),
    .addr_hi_o (addr_hi_o),
    .rsel_o    (rsel_o)
  );
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
  parameter int DATA_W = 68,
  parameter int MIDX_W = 3,
  parameter int AHI_W  = 2,
  parameter int RSEL_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_valid_i,
  input logic [1:0]          opc_i,
  input logic [RSEL_W-1:0]   rsel_cmd_i,
  input logic [DATA_W-1:0]   data_i,
  input logic                launch_o,
  input logic                proto_err_o,
  input logic [DATA_W*4-1:0] key_o,
  input logic [MIDX_W-1:0]   midx_hi_o,
  input logic [MIDX_W-1:0]   midx_lo_o,
  input logic [AHI_W-1:0]    addr_hi_o,
  input logic [RSEL_W-1:0]   rsel_o
);
  // R7
  launch_single_chk: assert property (@(posedge clk) disable iff (rst)
    launch_o |=> !launch_o);

  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err_o |=> !proto_err_o);

  // R8
  launch_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(launch_o && proto_err_o));

  // R1
  launch_qual_chk: assert property (@(posedge clk) disable iff (rst)
    launch_o |-> ($past(cmd_valid_i) && $past(opc_i) == 2'b10));

  // R3
  key_tail_chk: assert property (@(posedge clk) disable iff (rst)
    launch_o |-> key_o[DATA_W-1:0] == $past(data_i));

  // R6
  rsel_chk: assert property (@(posedge clk) disable iff (rst)
    launch_o |-> rsel_o == $past(rsel_cmd_i));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !launch_o |-> ($stable(key_o) && $stable(midx_hi_o) && $stable(midx_lo_o)
                   && $stable(addr_hi_o) && $stable(rsel_o)));
endmodule

bind wide_search_capture wsc_checker #(
  .DATA_W(DATA_W), .MIDX_W(MIDX_W), .AHI_W(AHI_W), .RSEL_W(RSEL_W)
) u_wsc_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid_i (cmd_valid_i),
  .opc_i       (cmd_i[1:0]),
  .rsel_cmd_i  (cmd_i[CMD_W-1 -: RSEL_W]),
  .data_i      (data_i),
  .launch_o    (launch_o),
  .proto_err_o (proto_err_o),
  .key_o       (key_o),
  .midx_hi_o   (midx_hi_o),
  .midx_lo_o   (midx_lo_o),
  .addr_hi_o   (addr_hi_o),
  .rsel_o      (rsel_o)
);

// File: tb/wide_search_capture_bench.sv
module wide_search_capture_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         cmd_valid;
  logic [8:0]   cmd;
  logic [67:0]  data;
  logic         launch, perr;
  logic [271:0] key;
  logic [2:0]   mhi, mlo, rsel;
  logic [1:0]   ahi;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wide_search_capture u_wide_search_capture (
    .clk(clk), .rst(rst), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .data_i(data),
    .launch_o(launch), .proto_err_o(perr), .key_o(key),
    .midx_hi_o(mhi), .midx_lo_o(mlo), .addr_hi_o(ahi), .rsel_o(rsel)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, logic [271:0] act, logic [271:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(bit v, logic [8:0] c, logic [67:0] d);
    @(negedge clk);
    cmd_valid = v;
    cmd = c;
    data = d;
  endtask

  task automatic flags(bit l, bit e, string tag);
    chk(launch == l, {tag, " launch"}, 272'(launch), 272'(l));
    chk(perr == e, {tag, " error"}, 272'(perr), 272'(e));
  endtask

  function automatic logic [67:0] word(int seed, int b);
    return {4'(b + 1), 32'(seed * 32'h9E3779B1) ^ 32'h5A5A0000, 32'(seed * 7 + b * 32'h01010101)};
  endfunction

  function automatic logic [271:0] full_key(int seed);
    return {word(seed, 0), word(seed, 1), word(seed, 2), word(seed, 3)};
  endfunction

  // one well-formed sequence; ignored positions carry values unlike the real fields
  task automatic send4(int hi, int lo, int ah, int sel, int seed);
    drive(1, {2'(~ah), 1'(seed), 3'(hi), 1'b1, 2'b10}, word(seed, 0));
    drive(1, {3'(seed + 5), 3'(seed + 1), 1'(seed >> 1), 2'b10}, word(seed, 1));
    drive(1, {2'(ah), 1'(~seed), 3'(lo), 1'b0, 2'b10}, word(seed, 2));
    drive(1, {3'(sel), 4'(seed * 3 + 1), 2'b10}, word(seed, 3));
  endtask

  task automatic check_out(int hi, int lo, int ah, int sel, int seed, string tag);
    chk(key == full_key(seed), {tag, " R3 key"}, key, full_key(seed));
    chk(mhi == 3'(hi), {tag, " R4 upper mask index"}, 272'(mhi), 272'(hi));
    chk(mlo == 3'(lo), {tag, " R4 lower mask index"}, 272'(mlo), 272'(lo));
    chk(ahi == 2'(ah), {tag, " R5 address bits"}, 272'(ahi), 272'(ah));
    chk(rsel == 3'(sel), {tag, " R6 register index"}, 272'(rsel), 272'(sel));
  endtask

  initial begin
    rst = 1'b1; cmd_valid = 0; cmd = '0; data = '0;
    repeat (3) @(negedge clk);
    chk(key == '0 && mhi == 0 && mlo == 0 && ahi == 0 && rsel == 0, "R10 reset outputs", key, '0);
    flags(0, 0, "R10 reset");
    @(negedge clk); rst = 1'b0;

    // R3 R4 R5 R6 R7 sweep of every field combination
    for (int h = 0; h < 8; h++)
      for (int l = 0; l < 8; l++)
        for (int a = 0; a < 4; a++)
          for (int s = 0; s < 8; s++) begin
            int sd;
            sd = h * 256 + l * 32 + a * 8 + s;
            send4(h, l, a, s, sd);
            drive(0, '0, '0);
            flags(1, 0, "R7 after beat D");
            check_out(h, l, a, s, sd, "sweep");
            drive(0, '0, '0);
            flags(0, 0, "R7 single pulse");
          end

    // R8 valid drops in place of beat B
    send4(1, 2, 3, 4, 77); drive(0, '0, '0); drive(0, '0, '0);
    drive(1, 9'b000_001_1_10, word(900, 0));
    drive(0, 9'b000_000_1_10, word(900, 1));
    drive(0, '0, '0);
    flags(0, 1, "R8 abort at B");
    drive(0, '0, '0);
    flags(0, 0, "R8 error one cycle");
    check_out(1, 2, 3, 4, 77, "R10 hold after abort B");

    // R8 wrong opcode in place of beat C
    drive(1, 9'b000_010_1_10, word(901, 0));
    drive(1, 9'b000_000_0_10, word(901, 1));
    drive(1, 9'b110_011_0_11, word(901, 2));
    drive(0, '0, '0);
    flags(0, 1, "R8 abort at C opcode");
    drive(0, '0, '0);
    flags(0, 0, "R8 error one cycle C");

    // R8 valid drops in place of beat D
    drive(1, 9'b000_010_1_10, word(902, 0));
    drive(1, 9'b000_000_0_10, word(902, 1));
    drive(1, 9'b110_011_0_10, word(902, 2));
    drive(0, 9'b111_000_0_10, word(902, 3));
    drive(0, '0, '0);
    flags(0, 1, "R8 abort at D");
    drive(0, '0, '0);
    flags(0, 0, "R8 error one cycle D");
    check_out(1, 2, 3, 4, 77, "R10 hold after abort D");

    // R9 width bit set in beat C; the aborting beat must not open a sequence
    drive(1, 9'b000_010_1_10, word(903, 0));
    drive(1, 9'b000_000_0_10, word(903, 1));
    drive(1, 9'b010_101_1_10, word(903, 2));
    drive(1, 9'b000_000_0_10, word(903, 3));
    flags(0, 1, "R9 abort at C width bit");
    drive(1, 9'b010_101_0_10, word(903, 4));
    flags(0, 0, "R8 stray beat ignored");
    drive(1, 9'b101_000_0_10, word(903, 5));
    flags(0, 0, "R8 stray beat C ignored");
    drive(0, '0, '0);
    flags(0, 0, "R8 stray beat D no launch");
    drive(0, '0, '0);
    flags(0, 0, "R8 quiet");

    // R2 R1 idle beats that must not start a sequence
    drive(1, 9'b000_011_0_10, word(904, 0));
    drive(0, 9'b000_011_1_10, word(904, 1));
    flags(0, 0, "R2 narrow beat ignored");
    drive(1, 9'b000_011_1_01, word(904, 2));
    flags(0, 0, "R1 invalid strobe ignored");
    drive(1, 9'b000_000_0_10, word(904, 3));
    flags(0, 0, "R1 wrong opcode ignored");
    drive(1, 9'b000_000_0_10, word(904, 4));
    flags(0, 0, "R2 idle B");
    drive(1, 9'b111_000_0_10, word(904, 5));
    flags(0, 0, "R2 idle C");
    drive(0, '0, '0);
    flags(0, 0, "R2 idle D");
    check_out(1, 2, 3, 4, 77, "R10 hold after idle beats");

    // R11 back-to-back sequences
    send4(5, 6, 1, 7, 1234);
    drive(1, {2'b00, 1'b0, 3'd3, 1'b1, 2'b10}, word(4321, 0));
    flags(1, 0, "R11 first launch");
    check_out(5, 6, 1, 7, 1234, "R11 first");
    drive(1, {3'd2, 3'd1, 1'b0, 2'b10}, word(4321, 1));
    flags(0, 0, "R11 gap");
    drive(1, {2'd2, 1'b1, 3'd4, 1'b0, 2'b10}, word(4321, 2));
    drive(1, {3'd6, 4'd9, 2'b10}, word(4321, 3));
    drive(0, '0, '0);
    flags(1, 0, "R11 second launch");
    chk(key == full_key(4321), "R11 second key", key, full_key(4321));
    chk(mhi == 3 && mlo == 4 && ahi == 2 && rsel == 6, "R11 second fields",
        272'({mhi, mlo, ahi, rsel}), 272'({3'd3, 3'd4, 2'd2, 3'd6}));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule